// File: doc/BRIEF.md
# Far-Return Segment Protection Checker

This block decides whether the code and stack segments named by a far return may be loaded. A surrounding load unit has already fetched and decoded both descriptors. It presents the two selectors, the decoded descriptor attributes, the descriptor-table limits, the current privilege level, the operating mode and the target offset with the code segment limit, and then pulses `start`.

One clock later the block pulses `done`. It reports either `pass` or a general-protection `fault`. A fault comes with a 4-bit cause code and the selector that caused it. When several rules are broken at once, only the highest-priority one is reported. Code selector checks come first, then code descriptor checks, then stack checks, then the offset checks. A lower code number means a higher priority.

Top module: `far_ret_prot_chk`

## Requirements
- R1: `done` is high for exactly the one cycle after a cycle with `start` high. `pass`, `fault`, `fault_code` and `err_sel` change only on that edge and hold until the next `start`. After reset, all outputs are 0.
- R2: A selector carries its table index in bits 15:3, its table select bit (TI, 1 = local table) in bit 2 and its requested privilege (RPL) in bits 1:0. It is null when the index and TI are both 0. A null code selector gives code 1 with `err_sel` 0.
- R3: Selector TI=1 while `ldt_null` is high gives code 2 for the code selector or code 9 for the stack selector. A selector with TI=0 is not affected by `ldt_null`.
- R4: A selector is out of range when index*8+7 exceeds its table limit: `gdt_limit` when TI=0 and `ldt_limit` when TI=1. This gives code 3 for the code selector or code 10 for the stack selector.
- R5: A code descriptor without the code attribute gives code 4. A code selector RPL below `cpl` gives code 5.
- R6: For a non-conforming code segment, a DPL not equal to the code selector RPL gives code 6. For a conforming code segment, a DPL greater than that RPL gives code 7.
- R7: A null stack selector gives code 8 with `err_sel` 0. The exception is 64-bit mode with `cpl` below 3: there it is accepted and all stack checks are skipped.
- R8: Each of these stack faults reports the stack selector:
  - a stack descriptor that is code or not writable gives code 11;
  - a stack DPL not equal to the code selector RPL gives code 12;
  - a stack selector RPL not equal to the code selector RPL gives code 13.
- R9: In 64-bit mode, an offset whose bits 63:47 are not all equal gives code 14 with `err_sel` 0. Outside 64-bit mode this check is ignored.
- R10: An offset greater than the zero-extended `cs_limit` gives code 15 with `err_sel` 0.
- R11: When several checks fail, the lowest code number is reported.
- R12: When no check fails, the result is `pass`=1, `fault`=0, `fault_code`=0 and `err_sel`=0. For codes 2–7 `err_sel` is the code selector, and for codes 9–13 it is the stack selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluate the present inputs |
| mode64 | input | 1 | Return mode is 64-bit |
| cpl | input | 2 | Current privilege level |
| cs_sel | input | 16 | Return code selector |
| ss_sel | input | 16 | Return stack selector |
| cs_is_code | input | 1 | Code descriptor is a code segment |
| cs_conf | input | 1 | Code segment is conforming |
| cs_dpl | input | 2 | Code descriptor DPL |
| ss_is_code | input | 1 | Stack descriptor is a code segment |
| ss_wr | input | 1 | Stack descriptor is writable |
| ss_dpl | input | 2 | Stack descriptor DPL |
| gdt_limit | input | 16 | Global descriptor table limit |
| ldt_limit | input | 16 | Local descriptor table limit |
| ldt_null | input | 1 | Local table selector is null |
| target_ofs | input | 64 | Return target offset |
| cs_limit | input | 32 | Code segment limit |
| done | output | 1 | Result valid pulse |
| pass | output | 1 | All checks passed |
| fault | output | 1 | General-protection fault |
| fault_code | output | 4 | Fault cause code |
| err_sel | output | 16 | Offending selector or 0 |

## Verification
The assertions check on every cycle the handshake timing and the holding of results between requests. They also check that `pass` and `fault` exclude each other, that a pass carries a zero code and selector, that a null code selector always yields code 1, and that an accepted null stack selector never leads to a stack fault. Only the bench scenarios can show the exact priority between simultaneous violations, the table-limit boundaries, the choice between the global and local limit, and the offset edge cases.

// File: rtl/frp_pkg.sv
package frp_pkg;

  localparam int NUM_CHK = 15;

  typedef enum logic [3:0] {
    FC_NONE      = 4'd0,
    FC_CS_NULL   = 4'd1,
    FC_CS_LDT    = 4'd2,
    FC_CS_LIM    = 4'd3,
    FC_CS_TYPE   = 4'd4,
    FC_CS_RPL    = 4'd5,
    FC_CS_NCDPL  = 4'd6,
    FC_CS_CDPL   = 4'd7,
    FC_SS_NULL   = 4'd8,
    FC_SS_LDT    = 4'd9,
    FC_SS_LIM    = 4'd10,
    FC_SS_TYPE   = 4'd11,
    FC_SS_DPL    = 4'd12,
    FC_SS_RPL    = 4'd13,
    FC_OFS_CANON = 4'd14,
    FC_OFS_LIM   = 4'd15
  } frp_fault_e;

  // Lowest set hit wins; hit i maps to code i+1.
  function automatic logic [3:0] first_fault(input logic [NUM_CHK-1:0] hits);
    logic [3:0] c;
    c = 4'd0;
    for (int i = NUM_CHK - 1; i >= 0; i--) begin
      if (hits[i]) c = 4'(i + 1);
    end
    return c;
  endfunction

  // 0: no selector reported, 1: code selector, 2: stack selector
  function automatic logic [1:0] err_source(input logic [3:0] code);
    if (code >= FC_CS_LDT && code <= FC_CS_CDPL) return 2'd1;
    if (code >= FC_SS_LDT && code <= FC_SS_RPL) return 2'd2;
    return 2'd0;
  endfunction

endpackage

// File: rtl/frp_sel_chk.sv
module frp_sel_chk #(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16
) (
  input  logic [SEL_W-1:2] sel_hi,
  input  logic [LIM_W-1:0] gdt_lim,
  input  logic [LIM_W-1:0] ldt_lim,
  input  logic             ldt_null,
  output logic             is_null,
  output logic             ldt_bad,
  output logic             lim_bad
);
  localparam int IDX_W = SEL_W - 3;
  localparam int CMP_W = (SEL_W > LIM_W) ? SEL_W : LIM_W;

  logic [IDX_W-1:0] idx;
  logic             ti;
  logic [SEL_W-1:0] last_byte;
  logic [LIM_W-1:0] lim;

  assign idx       = sel_hi[SEL_W-1:3];
  assign ti        = sel_hi[2];
  assign last_byte = {idx, 3'b111};
  assign lim       = ti ? ldt_lim : gdt_lim;

  assign is_null = (idx == '0) && !ti;
  assign ldt_bad = ti && ldt_null;
  assign lim_bad = CMP_W'(last_byte) > CMP_W'(lim);
endmodule

// File: rtl/frp_desc_chk.sv
module frp_desc_chk #(
  parameter int PL_W = 2
) (
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] cs_rpl,
  input  logic [PL_W-1:0] ss_rpl,
  input  logic            cs_is_code,
  input  logic            cs_conf,
  input  logic [PL_W-1:0] cs_dpl,
  input  logic            ss_is_code,
  input  logic            ss_wr,
  input  logic [PL_W-1:0] ss_dpl,
  output logic            cs_type_bad,
  output logic            cs_rpl_bad,
  output logic            cs_ncdpl_bad,
  output logic            cs_cdpl_bad,
  output logic            ss_type_bad,
  output logic            ss_dpl_bad,
  output logic            ss_rpl_bad
);
  assign cs_type_bad  = !cs_is_code;
  assign cs_rpl_bad   = cs_rpl < cpl;
  assign cs_ncdpl_bad = !cs_conf && (cs_dpl != cs_rpl);
  assign cs_cdpl_bad  = cs_conf && (cs_dpl > cs_rpl);
  assign ss_type_bad  = ss_is_code || !ss_wr;
  assign ss_dpl_bad   = ss_dpl != cs_rpl;
  assign ss_rpl_bad   = ss_rpl != cs_rpl;
endmodule

// File: rtl/frp_ofs_chk.sv
module frp_ofs_chk #(
  parameter int OFS_W  = 64,
  parameter int LIM_W  = 32,
  parameter int VA_MSB = 47
) (
  input  logic             mode64,
  input  logic [OFS_W-1:0] ofs,
  input  logic [LIM_W-1:0] lim,
  output logic             noncanon,
  output logic             over_lim
);
  localparam int UP_W = OFS_W - VA_MSB;

  function automatic logic upper_uniform(input logic [UP_W-1:0] up);
    return (&up) || (~|up);
  endfunction

  assign noncanon = mode64 && !upper_uniform(ofs[OFS_W-1:VA_MSB]);
  assign over_lim = ofs > OFS_W'(lim);
endmodule

// File: rtl/far_ret_prot_chk.sv
module far_ret_prot_chk #(
  parameter int SEL_W   = 16,
  parameter int TLIM_W  = 16,
  parameter int PL_W    = 2,
  parameter int OFS_W   = 64,
  parameter int CLIM_W  = 32,
  parameter int VA_MSB  = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode64,
  input  logic [PL_W-1:0]   cpl,
  input  logic [SEL_W-1:0]  cs_sel,
  input  logic [SEL_W-1:0]  ss_sel,
  input  logic              cs_is_code,
  input  logic              cs_conf,
  input  logic [PL_W-1:0]   cs_dpl,
  input  logic              ss_is_code,
  input  logic              ss_wr,
  input  logic [PL_W-1:0]   ss_dpl,
  input  logic [TLIM_W-1:0] gdt_limit,
  input  logic [TLIM_W-1:0] ldt_limit,
  input  logic              ldt_null,
  input  logic [OFS_W-1:0]  target_ofs,
  input  logic [CLIM_W-1:0] cs_limit,
  output logic              done,
  output logic              pass,
  output logic              fault,
  output logic [3:0]        fault_code,
  output logic [SEL_W-1:0]  err_sel
);
  import frp_pkg::*;

  localparam logic [PL_W-1:0] PL_MAX = '1;

  // Selector table checks, one instance per selector (0: code, 1: stack)
  logic [SEL_W-1:0] sel_arr [2];
  logic [1:0]       s_null, s_ldt, s_lim;

  assign sel_arr[0] = cs_sel;
  assign sel_arr[1] = ss_sel;

  for (genvar g = 0; g < 2; g++) begin : g_sel
    frp_sel_chk #(.SEL_W(SEL_W), .LIM_W(TLIM_W)) u_sel (
      .sel_hi   (sel_arr[g][SEL_W-1:2]),
      .gdt_lim  (gdt_limit),
      .ldt_lim  (ldt_limit),
      .ldt_null (ldt_null),
      .is_null  (s_null[g]),
      .ldt_bad  (s_ldt[g]),
      .lim_bad  (s_lim[g])
    );
  end

  logic cs_type_bad, cs_rpl_bad, cs_ncdpl_bad, cs_cdpl_bad;
  logic ss_type_bad, ss_dpl_bad, ss_rpl_bad;

  frp_desc_chk #(.PL_W(PL_W)) u_desc (
    .cpl          (cpl),
    .cs_rpl       (cs_sel[PL_W-1:0]),
    .ss_rpl       (ss_sel[PL_W-1:0]),
    .cs_is_code   (cs_is_code),
    .cs_conf      (cs_conf),
    .cs_dpl       (cs_dpl),
    .ss_is_code   (ss_is_code),
    .ss_wr        (ss_wr),
    .ss_dpl       (ss_dpl),
    .cs_type_bad  (cs_type_bad),
    .cs_rpl_bad   (cs_rpl_bad),
    .cs_ncdpl_bad (cs_ncdpl_bad),
    .cs_cdpl_bad  (cs_cdpl_bad),
    .ss_type_bad  (ss_type_bad),
    .ss_dpl_bad   (ss_dpl_bad),
    .ss_rpl_bad   (ss_rpl_bad)
  );

  logic ofs_noncanon, ofs_over;

  frp_ofs_chk #(.OFS_W(OFS_W), .LIM_W(CLIM_W), .VA_MSB(VA_MSB)) u_ofs (
    .mode64   (mode64),
    .ofs      (target_ofs),
    .lim      (cs_limit),
    .noncanon (ofs_noncanon),
    .over_lim (ofs_over)
  );

  // Null stack selector accepted: 64-bit return to a privileged level
  logic ss_null_ok;
  logic ss_live;
  assign ss_null_ok = s_null[1] && mode64 && (cpl != PL_MAX);
  assign ss_live    = !ss_null_ok;

  logic [NUM_CHK-1:0] hits;
  assign hits = {
    ofs_over,
    ofs_noncanon,
    ss_live && ss_rpl_bad,
    ss_live && ss_dpl_bad,
    ss_live && ss_type_bad,
    ss_live && s_lim[1],
    ss_live && s_ldt[1],
    ss_live && s_null[1],
    cs_cdpl_bad,
    cs_ncdpl_bad,
    cs_rpl_bad,
    cs_type_bad,
    s_lim[0],
    s_ldt[0],
    s_null[0]
  };

  logic [3:0]       fc_next;
  logic [SEL_W-1:0] es_next;

  assign fc_next = first_fault(hits);

  always_comb begin
    unique case (err_source(fc_next))
      2'd1:    es_next = cs_sel;
      2'd2:    es_next = ss_sel;
      default: es_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      pass       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= 4'd0;
      err_sel    <= '0;
    end else begin
      done <= start;
      if (start) begin
        pass       <= (fc_next == FC_NONE);
        fault      <= (fc_next != FC_NONE);
        fault_code <= fc_next;
        err_sel    <= es_next;
      end
    end
  end
endmodule

// File: rtl/frp_chk.sv
module frp_chk #(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [SEL_W-1:0] cs_sel,
  input logic             ss_null_ok,
  input logic             done,
  input logic             pass,
  input logic             fault,
  input logic [3:0]       fault_code,
  input logic [SEL_W-1:0] err_sel
);
  // R1
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R1
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(fault_code) && $stable(err_sel) && $stable(pass) && $stable(fault)));

  // R12
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fault));

  // R12
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (fault_code == 4'd0 && err_sel == '0));

  // R2
  cs_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cs_sel[SEL_W-1:2] == '0) |=> (fault_code == 4'd1 && err_sel == '0));

  // R7
  ss_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ss_null_ok) |=> (fault_code < 4'd8 || fault_code > 4'd13));
endmodule

bind far_ret_prot_chk frp_chk #(.SEL_W(SEL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .cs_sel     (cs_sel),
  .ss_null_ok (ss_null_ok),
  .done       (done),
  .pass       (pass),
  .fault      (fault),
  .fault_code (fault_code),
  .err_sel    (err_sel)
);

// File: tb/far_ret_prot_chk_tb_top.sv
module far_ret_prot_chk_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode64 = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic [15:0] cs_sel = 16'h0010;
  logic [15:0] ss_sel = 16'h0018;
  logic        cs_is_code = 1'b1;
  logic        cs_conf = 1'b0;
  logic [1:0]  cs_dpl = 2'd0;
  logic        ss_is_code = 1'b0;
  logic        ss_wr = 1'b1;
  logic [1:0]  ss_dpl = 2'd0;
  logic [15:0] gdt_limit = 16'h00FF;
  logic [15:0] ldt_limit = 16'h003F;
  logic        ldt_null = 1'b0;
  logic [63:0] target_ofs = 64'h1000;
  logic [31:0] cs_limit = 32'h0000_FFFF;
  logic        done, pass, fault;
  logic [3:0]  fault_code;
  logic [15:0] err_sel;

  always #2 clk = ~clk;

  far_ret_prot_chk dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode64(mode64), .cpl(cpl),
    .cs_sel(cs_sel), .ss_sel(ss_sel), .cs_is_code(cs_is_code), .cs_conf(cs_conf),
    .cs_dpl(cs_dpl), .ss_is_code(ss_is_code), .ss_wr(ss_wr), .ss_dpl(ss_dpl),
    .gdt_limit(gdt_limit), .ldt_limit(ldt_limit), .ldt_null(ldt_null),
    .target_ofs(target_ofs), .cs_limit(cs_limit), .done(done), .pass(pass),
    .fault(fault), .fault_code(fault_code), .err_sel(err_sel)
  );

  typedef struct packed {
    logic        m64;
    logic [1:0]  cpl;
    logic [15:0] cs;
    logic [15:0] ss;
    logic        cc;
    logic        cf;
    logic [1:0]  cd;
    logic        sc;
    logic        sw;
    logic [1:0]  sd;
    logic [63:0] ofs;
    logic [3:0]  ec;
    logic [15:0] es;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd0,  16'h0000}, // R12 pass
    '{1'b0, 2'd0, 16'h0000, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd1,  16'h0000}, // R2
    '{1'b0, 2'd0, 16'h0003, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd1,  16'h0000}, // R2 rpl ignored
    '{1'b0, 2'd0, 16'h0140, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd3,  16'h0140}, // R4
    '{1'b0, 2'd0, 16'h0010, 16'h0018, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd4,  16'h0010}, // R5
    '{1'b0, 2'd1, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd5,  16'h0010}, // R5
    '{1'b0, 2'd0, 16'h0013, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd6,  16'h0013}, // R6
    '{1'b0, 2'd0, 16'h0011, 16'h0018, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd7,  16'h0011}, // R6
    '{1'b0, 2'd0, 16'h0011, 16'h0019, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 2'd1, 64'h1000, 4'd0,  16'h0000}, // R6 conforming ok
    '{1'b0, 2'd0, 16'h0010, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd8,  16'h0000}, // R7 legacy
    '{1'b1, 2'd0, 16'h0010, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd0,  16'h0000}, // R7 accepted
    '{1'b1, 2'd3, 16'h0013, 16'h0000, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd8,  16'h0000}, // R7 cpl3
    '{1'b0, 2'd0, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 64'h1000, 4'd11, 16'h0018}, // R8
    '{1'b0, 2'd0, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0, 64'h1000, 4'd11, 16'h0018}, // R8
    '{1'b0, 2'd0, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 64'h1000, 4'd12, 16'h0018}, // R8
    '{1'b0, 2'd0, 16'h0010, 16'h001B, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd13, 16'h001B}, // R8
    '{1'b1, 2'd0, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h0000_8000_0000_0000, 4'd14, 16'h0000}, // R9
    '{1'b1, 2'd0, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'hFFFF_8000_0000_0000, 4'd15, 16'h0000}, // R10
    '{1'b0, 2'd0, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h0001_0000, 4'd15, 16'h0000}, // R10
    '{1'b0, 2'd0, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h0000_8000_0000_0000, 4'd15, 16'h0000}, // R9 ignored in legacy
    '{1'b0, 2'd0, 16'h0010, 16'h0018, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h0000_FFFF, 4'd0, 16'h0000}, // R10 at limit
    '{1'b0, 2'd0, 16'h0010, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd4,  16'h0010}, // R11
    '{1'b0, 2'd0, 16'h0010, 16'h0140, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h1000, 4'd10, 16'h0140}, // R4
    '{1'b1, 2'd3, 16'h0013, 16'h001B, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 2'd3, 64'h1000, 4'd0,  16'h0000}, // R12
    '{1'b0, 2'd0, 16'h0010, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 64'h0001_0000, 4'd8, 16'h0000}  // R11
  };

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got done/pass/fault/code/sel=%h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] expect_of(input logic [3:0] ec, input logic [15:0] es);
    return {1'b1, ec == 4'd0, ec != 4'd0, ec, es};
  endfunction

  task automatic apply_and_check(input string req, input logic [3:0] ec, input logic [15:0] es);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(req, {done, pass, fault, fault_code, err_sel}, expect_of(ec, es));
  endtask

  task automatic load_base();
    mode64 = 1'b0; cpl = 2'd0; cs_sel = 16'h0010; ss_sel = 16'h0018;
    cs_is_code = 1'b1; cs_conf = 1'b0; cs_dpl = 2'd0;
    ss_is_code = 1'b0; ss_wr = 1'b1; ss_dpl = 2'd0;
    ldt_null = 1'b0; target_ofs = 64'h1000;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1: watchdog expired, got no finish expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {done, pass, fault, fault_code, err_sel}, 23'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {done, pass, fault, fault_code, err_sel}, 23'd0);

    for (int i = 0; i < NV; i++) begin
      mode64 = VECS[i].m64; cpl = VECS[i].cpl; cs_sel = VECS[i].cs; ss_sel = VECS[i].ss;
      cs_is_code = VECS[i].cc; cs_conf = VECS[i].cf; cs_dpl = VECS[i].cd;
      ss_is_code = VECS[i].sc; ss_wr = VECS[i].sw; ss_dpl = VECS[i].sd;
      target_ofs = VECS[i].ofs;
      apply_and_check($sformatf("vector %0d (R2-R12)", i), VECS[i].ec, VECS[i].es);
    end

    // R3 local table null
    load_base(); ldt_null = 1'b1; cs_sel = 16'h0014;
    apply_and_check("R3 code TI with null local table", 4'd2, 16'h0014);
    load_base(); ldt_null = 1'b1; ss_sel = 16'h001C;
    apply_and_check("R3 stack TI with null local table", 4'd9, 16'h001C);
    load_base(); ldt_null = 1'b1;
    apply_and_check("R3 null local table ignored for TI=0", 4'd0, 16'h0000);

    // R4 limit boundaries and table choice
    load_base(); cs_sel = 16'h00F8;
    apply_and_check("R4 code index at global limit", 4'd0, 16'h0000);
    load_base(); cs_sel = 16'h0100;
    apply_and_check("R4 code index past global limit", 4'd3, 16'h0100);
    load_base(); cs_sel = 16'h000C; ss_sel = 16'h003C;
    apply_and_check("R4 local table at its limit", 4'd0, 16'h0000);
    load_base(); ss_sel = 16'h0044;
    apply_and_check("R4 stack past local limit", 4'd10, 16'h0044);

    // R1 hold and one-cycle done
    load_base(); cs_is_code = 1'b0;
    apply_and_check("R1 setup", 4'd4, 16'h0010);
    load_base();
    repeat (3) @(negedge clk);
    check("R1 hold without start", {done, pass, fault, fault_code, err_sel},
          {1'b0, 1'b0, 1'b1, 4'd4, 16'h0010});

    finish_run();
  end
endmodule